// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO with Command Capture

This block is the byte queue that sits behind the single data-port address of a small SCSI initiator controller. Software moves data one byte at a time. A write to the port normally queues the byte in a data ring. While the command-capture flag is high, the byte goes into a separate command buffer instead, and the data level is left alone. A read removes one byte and raises a one-cycle interrupt request. During a data-out bus phase the read returns zero and the read position stays where it is.

A three-state fill controller holds the data ring's condition:

- **EMPTY**: level 0.
- **PARTIAL**: level 1 to DEPTH-2.
- **EDGE**: level DEPTH-1. This is the highest level the ring accepts.

Its transitions are:

- **PUSH**: EMPTY to PARTIAL, or PARTIAL to EDGE on the last slot.
- **POP**: EDGE to PARTIAL, or PARTIAL to PARTIAL.
- **POP_LAST**: any non-empty state to EMPTY, which also rewinds both ring positions.
- **REJECT**: EDGE to EDGE, which sets the overrun flag.

Command captures, dropped captures and reads of an empty ring leave the fill state unchanged. The neighbouring sequencer reads the captured command through an index port.

Top module: `pio_fifo`

## Requirements
- R1: A synchronous reset (srst high at a clock edge) clears the level, the command length, the overrun flag, the interrupt pulse and the read byte to zero.
- R2: A write with capture_mode low and level below DEPTH-1 (15) stores the byte and raises the level by one. A write at level 15 is dropped, leaves the level unchanged and sets the overrun flag.
- R3: A write with capture_mode high stores the byte at command index cmd_len and increments cmd_len, leaving the level unchanged. When cmd_len already equals CMD_DEPTH (16) the byte is dropped and the overrun flag is set.
- R4: A read with a nonzero level lowers the level by one and drives irq_pulse high for exactly the cycle after the read edge.
- R5: When phase_field is not 00, a read with a nonzero level returns the oldest queued byte on rd_byte after the edge and advances the read position. When phase_field is 00 (data-out), it returns 0x00 and the read position stays put.
- R6: A read that brings the level to zero rewinds both the read and write positions to slot 0, so the next byte written is the next byte read.
- R7: A read at level zero changes no state: rd_byte keeps its last value, the level is unchanged and no interrupt pulse is raised.
- R8: When rd_en and wr_en are both high, the read is served and the write is ignored.
- R9: The ring positions wrap from slot DEPTH-1 to slot 0, so bytes leave in the order written across the wrap.
- R10: The overrun flag stays set until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the data port |
| wr_byte | input | 8 | Byte written |
| rd_en | input | 1 | Read strobe for the data port |
| rd_byte | output | 8 | Latched byte from the last effective read |
| capture_mode | input | 1 | High: writes go to the command buffer |
| phase_field | input | 2 | Bus phase field; 00 is data-out |
| irq_pulse | output | 1 | One-cycle interrupt request after a read |
| level | output | 4 | Bytes held in the data ring |
| cmd_len | output | 5 | Bytes held in the command buffer |
| cmd_idx | input | 4 | Command buffer index to look at |
| cmd_byte | output | 8 | Command byte at cmd_idx |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Short fill-and-drain runs in a data-in phase confirm ordering. Data-out reads confirm that the read position does not move, and following them with a rewind to an empty ring separates a correct rewind from a stale read position, because a missing rewind returns an old byte. Filling to 15 and pushing once more, and capturing 17 command bytes, locate each overrun boundary exactly. Simultaneous strobes, reads of an empty ring, a fill that straddles the wrap, and a long pseudo-random mix of all strobes and phases are compared against a behavioural model on every cycle.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;

    typedef enum logic [1:0] {
        FS_EMPTY   = 2'd0,
        FS_PARTIAL = 2'd1,
        FS_EDGE    = 2'd2
    } fill_state_t;

    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_PUSH     = 3'd1,
        OP_REJECT   = 3'd2,
        OP_CAPTURE  = 3'd3,
        OP_CAP_DROP = 3'd4,
        OP_POP      = 3'd5,
        OP_RD_EMPTY = 3'd6
    } port_op_t;

endpackage

// File: rtl/pio_fifo_ctrl.sv
module pio_fifo_ctrl
    import pio_fifo_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int CMD_DEPTH = 16,
    localparam int AW  = $clog2(DEPTH),
    localparam int LW  = $clog2(DEPTH),
    localparam int CLW = $clog2(CMD_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              capture_mode,
    input  logic [1:0]        phase_field,
    output fill_state_t       state,
    output logic [LW-1:0]     level,
    output logic [AW-1:0]     rptr,
    output logic [AW-1:0]     wptr,
    output logic [CLW-1:0]    cmd_len,
    output logic              overrun,
    output logic              irq_pulse,
    output logic              store_we,
    output logic              load_en,
    output logic              load_zero,
    output logic              cmd_we
);

    localparam logic [LW-1:0]  LVL_TOP  = LW'(DEPTH - 1);
    localparam logic [LW-1:0]  LVL_NEAR = LW'(DEPTH - 2);
    localparam logic [LW-1:0]  LVL_ONE  = LW'(1);
    localparam logic [CLW-1:0] CMD_FULL = CLW'(CMD_DEPTH);
    localparam logic [AW-1:0]  PTR_TOP  = AW'(DEPTH - 1);

    port_op_t    op;
    fill_state_t state_nx;
    logic        is_dataout;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == PTR_TOP) ? '0 : p + 1'b1;
    endfunction

    assign is_dataout = (phase_field == 2'b00);

    // Decode the port access; a read wins over a write (R8)
    always_comb begin
        op = OP_IDLE;
        if (rd_en) begin
            op = (state == FS_EMPTY) ? OP_RD_EMPTY : OP_POP;
        end else if (wr_en) begin
            if (capture_mode) begin
                op = (cmd_len == CMD_FULL) ? OP_CAP_DROP : OP_CAPTURE;
            end else begin
                op = (state == FS_EDGE) ? OP_REJECT : OP_PUSH;
            end
        end
    end

    // Fill-state transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            FS_EMPTY: begin
                if (op == OP_PUSH) state_nx = FS_PARTIAL;
            end
            FS_PARTIAL: begin
                if (op == OP_PUSH && level == LVL_NEAR)     state_nx = FS_EDGE;
                else if (op == OP_POP && level == LVL_ONE)  state_nx = FS_EMPTY;
            end
            FS_EDGE: begin
                if (op == OP_POP) state_nx = FS_PARTIAL;
            end
            default: state_nx = FS_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (srst) state <= FS_EMPTY;
        else      state <= state_nx;
    end

    // Counters, positions and flags
    always_ff @(posedge clk) begin
        if (srst) begin
            level     <= '0;
            rptr      <= '0;
            wptr      <= '0;
            cmd_len   <= '0;
            overrun   <= 1'b0;
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= 1'b0;
            unique case (op)
                OP_PUSH: begin
                    level <= level + 1'b1;
                    wptr  <= ptr_inc(wptr);
                end
                OP_REJECT: overrun <= 1'b1;
                OP_CAPTURE: cmd_len <= cmd_len + 1'b1;
                OP_CAP_DROP: overrun <= 1'b1;
                OP_POP: begin
                    level     <= level - 1'b1;
                    irq_pulse <= 1'b1;
                    if (level == LVL_ONE) begin
                        rptr <= '0;
                        wptr <= '0;
                    end else if (!is_dataout) begin
                        rptr <= ptr_inc(rptr);
                    end
                end
                OP_IDLE, OP_RD_EMPTY: begin
                end
                default: begin
                end
            endcase
        end
    end

    // Strobes to the storage blocks
    always_comb begin
        store_we  = (op == OP_PUSH);
        cmd_we    = (op == OP_CAPTURE);
        load_en   = (op == OP_POP);
        load_zero = is_dataout;
    end

endmodule

// File: rtl/pio_fifo_store.sv
module pio_fifo_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          load_en,
    input  logic          load_zero,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rd_q
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (srst)          rd_q <= '0;
        else if (load_en)  rd_q <= load_zero ? '0 : mem[raddr];
    end

endmodule

// File: rtl/pio_cmd_store.sv
module pio_cmd_store #(
    parameter int DW        = 8,
    parameter int CMD_DEPTH = 16,
    localparam int CAW = $clog2(CMD_DEPTH)
) (
    input  logic           clk,
    input  logic           we,
    input  logic [CAW-1:0] widx,
    input  logic [DW-1:0]  wdata,
    input  logic [CAW-1:0] ridx,
    output logic [DW-1:0]  rdata
);

    logic [DW-1:0] mem [CMD_DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign rdata = mem[ridx];

endmodule

// File: rtl/pio_fifo.sv
module pio_fifo
    import pio_fifo_pkg::*;
#(
    parameter int DW        = 8,
    parameter int DEPTH     = 16,
    parameter int CMD_DEPTH = 16,
    localparam int AW  = $clog2(DEPTH),
    localparam int LW  = $clog2(DEPTH),
    localparam int CAW = $clog2(CMD_DEPTH),
    localparam int CLW = $clog2(CMD_DEPTH + 1)
) (
    input  logic           clk,
    input  logic           srst,
    input  logic           wr_en,
    input  logic [DW-1:0]  wr_byte,
    input  logic           rd_en,
    output logic [DW-1:0]  rd_byte,
    input  logic           capture_mode,
    input  logic [1:0]     phase_field,
    output logic           irq_pulse,
    output logic [LW-1:0]  level,
    output logic [CLW-1:0] cmd_len,
    input  logic [CAW-1:0] cmd_idx,
    output logic [DW-1:0]  cmd_byte,
    output logic           overrun
);

    fill_state_t   fill_state;
    logic [AW-1:0] rptr;
    logic [AW-1:0] wptr;
    logic          store_we;
    logic          load_en;
    logic          load_zero;
    logic          cmd_we;

    pio_fifo_ctrl #(
        .DEPTH     (DEPTH),
        .CMD_DEPTH (CMD_DEPTH)
    ) u_ctrl (
        .clk          (clk),
        .srst         (srst),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .capture_mode (capture_mode),
        .phase_field  (phase_field),
        .state        (fill_state),
        .level        (level),
        .rptr         (rptr),
        .wptr         (wptr),
        .cmd_len      (cmd_len),
        .overrun      (overrun),
        .irq_pulse    (irq_pulse),
        .store_we     (store_we),
        .load_en      (load_en),
        .load_zero    (load_zero),
        .cmd_we       (cmd_we)
    );

    pio_fifo_store #(
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_store (
        .clk       (clk),
        .srst      (srst),
        .we        (store_we),
        .waddr     (wptr),
        .wdata     (wr_byte),
        .load_en   (load_en),
        .load_zero (load_zero),
        .raddr     (rptr),
        .rd_q      (rd_byte)
    );

    pio_cmd_store #(
        .DW        (DW),
        .CMD_DEPTH (CMD_DEPTH)
    ) u_cmd (
        .clk   (clk),
        .we    (cmd_we),
        .widx  (cmd_len[CAW-1:0]),
        .wdata (wr_byte),
        .ridx  (cmd_idx),
        .rdata (cmd_byte)
    );

endmodule

// File: rtl/pio_fifo_chk.sv
module pio_fifo_chk
    import pio_fifo_pkg::*;
#(
    parameter int DW        = 8,
    parameter int DEPTH     = 16,
    parameter int CMD_DEPTH = 16,
    localparam int LW  = $clog2(DEPTH),
    localparam int CLW = $clog2(CMD_DEPTH + 1)
) (
    input logic           clk,
    input logic           srst,
    input logic           wr_en,
    input logic           rd_en,
    input logic           capture_mode,
    input logic [LW-1:0]  level,
    input logic [CLW-1:0] cmd_len,
    input logic           overrun,
    input logic           irq_pulse,
    input logic [DW-1:0]  rd_byte,
    input fill_state_t    fill_state
);

    localparam logic [LW-1:0] LVL_TOP = LW'(DEPTH - 1);

    // R1: reset clears the visible state
    a_r1_reset_clears: assert property (@(posedge clk)
        srst |=> (level == '0 && cmd_len == '0 && !overrun && !irq_pulse));

    // R2: fill state agrees with the level counter
    a_r2_state_matches_level: assert property (@(posedge clk) disable iff (srst)
        ((fill_state == FS_EMPTY) == (level == '0)) &&
        ((fill_state == FS_EDGE) == (level == LVL_TOP)));

    // R2: a write at the top level is refused
    a_r2_reject_at_top: assert property (@(posedge clk) disable iff (srst)
        (wr_en && !rd_en && !capture_mode && level == LVL_TOP)
        |=> (level == LVL_TOP && overrun));

    // R3: capture leaves the data level alone
    a_r3_capture_keeps_level: assert property (@(posedge clk) disable iff (srst)
        (wr_en && !rd_en && capture_mode) |=> $stable(level));

    // R4: an effective read pulses the interrupt
    a_r4_irq_after_read: assert property (@(posedge clk) disable iff (srst)
        (rd_en && level != '0) |=> (irq_pulse && level == $past(level) - 1'b1));

    // R4: the interrupt only follows a read
    a_r4_irq_only_on_read: assert property (@(posedge clk) disable iff (srst)
        !(rd_en && level != '0) |=> !irq_pulse);

    // R7: read at zero level is inert
    a_r7_empty_read_inert: assert property (@(posedge clk) disable iff (srst)
        (rd_en && level == '0) |=> ($stable(level) && $stable(rd_byte) && !irq_pulse));

    // R8: simultaneous strobes never grow the level
    a_r8_read_wins: assert property (@(posedge clk) disable iff (srst)
        (rd_en && wr_en) |=> (level <= $past(level)));

    // R10: overrun is sticky
    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (srst)
        overrun |=> overrun);

endmodule

bind pio_fifo pio_fifo_chk #(
    .DW        (DW),
    .DEPTH     (DEPTH),
    .CMD_DEPTH (CMD_DEPTH)
) u_chk (
    .clk          (clk),
    .srst         (srst),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .capture_mode (capture_mode),
    .level        (level),
    .cmd_len      (cmd_len),
    .overrun      (overrun),
    .irq_pulse    (irq_pulse),
    .rd_byte      (rd_byte),
    .fill_state   (fill_state)
);

// File: tb/sim_pio_fifo.sv
`timescale 1ns/1ps
module sim_pio_fifo;

    logic       clk = 1'b0;
    logic       srst;
    logic       wr_en;
    logic [7:0] wr_byte;
    logic       rd_en;
    logic [7:0] rd_byte;
    logic       capture_mode;
    logic [1:0] phase_field;
    logic       irq_pulse;
    logic [3:0] level;
    logic [4:0] cmd_len;
    logic [3:0] cmd_idx;
    logic [7:0] cmd_byte;
    logic       overrun;

    always #2.5 clk = ~clk;

    pio_fifo u0 (
        .clk          (clk),
        .srst         (srst),
        .wr_en        (wr_en),
        .wr_byte      (wr_byte),
        .rd_en        (rd_en),
        .rd_byte      (rd_byte),
        .capture_mode (capture_mode),
        .phase_field  (phase_field),
        .irq_pulse    (irq_pulse),
        .level        (level),
        .cmd_len      (cmd_len),
        .cmd_idx      (cmd_idx),
        .cmd_byte     (cmd_byte),
        .overrun      (overrun)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Behavioural reference
    int         m_level, m_rp, m_wp, m_cmdlen;
    bit         m_ovr, m_irq;
    logic [7:0] m_rd;
    logic [7:0] m_mem [16];
    logic [7:0] m_cmd [16];

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R2", "level", int'(level), m_level);
        check("R5", "rd_byte", int'(rd_byte), int'(m_rd));
        check("R4", "irq_pulse", int'(irq_pulse), int'(m_irq));
        check("R3", "cmd_len", int'(cmd_len), m_cmdlen);
        check("R10", "overrun", int'(overrun), int'(m_ovr));
        if (int'(cmd_idx) < m_cmdlen)
            check("R3", "cmd_byte", int'(cmd_byte), int'(m_cmd[cmd_idx]));
    endtask

    task automatic model_reset();
        m_level = 0; m_rp = 0; m_wp = 0; m_cmdlen = 0;
        m_ovr = 1'b0; m_irq = 1'b0; m_rd = 8'h00;
    endtask

    // One port cycle: drive after a falling edge, compare at the next one
    task automatic step(input bit wr, input bit rd, input logic [7:0] d,
                        input bit cap, input logic [1:0] ph, input logic [3:0] ci);
        wr_en = wr; rd_en = rd; wr_byte = d; capture_mode = cap;
        phase_field = ph; cmd_idx = ci;
        m_irq = 1'b0;
        if (rd) begin
            if (m_level > 0) begin
                m_level--;
                m_irq = 1'b1;
                if (ph != 2'b00) begin
                    m_rd = m_mem[m_rp];
                    m_rp = (m_rp + 1) % 16;
                end else begin
                    m_rd = 8'h00;
                end
                if (m_level == 0) begin
                    m_rp = 0; m_wp = 0;
                end
            end
        end else if (wr) begin
            if (cap) begin
                if (m_cmdlen < 16) begin
                    m_cmd[m_cmdlen] = d;
                    m_cmdlen++;
                end else m_ovr = 1'b1;
            end else begin
                if (m_level == 15) m_ovr = 1'b1;
                else begin
                    m_mem[m_wp] = d;
                    m_wp = (m_wp + 1) % 16;
                    m_level++;
                end
            end
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic push(input logic [7:0] d);
        step(1'b1, 1'b0, d, 1'b0, 2'b01, 4'd0);
    endtask

    task automatic pop(input logic [1:0] ph);
        step(1'b0, 1'b1, 8'h00, 1'b0, ph, 4'd0);
    endtask

    task automatic do_reset();
        srst = 1'b1;
        wr_en = 1'b0; rd_en = 1'b0; capture_mode = 1'b0;
        @(negedge clk);
        @(negedge clk);
        srst = 1'b0;
        model_reset();
        compare_all();   // R1
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] lfsr;
        srst = 1'b1;
        wr_en = 1'b0; rd_en = 1'b0; wr_byte = 8'h00;
        capture_mode = 1'b0; phase_field = 2'b01; cmd_idx = 4'd0;
        model_reset();
        do_reset();                         // R1 reset state

        // R2 R4 R5: data-in ordering
        push(8'h11); push(8'h22); push(8'h33);
        pop(2'b01); pop(2'b11);

        // R5 R6: data-out reads then rewind; the next byte must come back
        pop(2'b00);
        push(8'h44);
        pop(2'b10);

        // R6: rewind after data-out drain with a stale read position
        push(8'h51); push(8'h52); push(8'h53);
        pop(2'b01);
        pop(2'b00); pop(2'b00);
        push(8'h5A);
        pop(2'b01);

        // R7: empty reads are inert
        pop(2'b01); pop(2'b00);

        // R2 R10: fill to the top, one more is refused
        for (int i = 0; i < 16; i++) push(8'hA0 + 8'(i));
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 8'h00, 1'b0, 2'b01, 4'd0);
        for (int i = 0; i < 15; i++) pop(2'b01);

        // R3: capture into the command buffer, level untouched
        push(8'h77);
        for (int i = 0; i < 17; i++)
            step(1'b1, 1'b0, 8'hC0 + 8'(i), 1'b1, 2'b01, 4'(i));
        for (int i = 0; i < 16; i++)
            step(1'b0, 1'b0, 8'h00, 1'b1, 2'b01, 4'(i));
        pop(2'b01);

        // R8: simultaneous strobes
        push(8'h61);
        step(1'b1, 1'b1, 8'h62, 1'b0, 2'b01, 4'd0);
        step(1'b1, 1'b1, 8'h63, 1'b0, 2'b01, 4'd0);

        // R9: fill straddling the wrap
        for (int i = 0; i < 10; i++) push(8'h80 + 8'(i));
        for (int i = 0; i < 8; i++) pop(2'b01);
        for (int i = 0; i < 10; i++) push(8'h90 + 8'(i));
        for (int i = 0; i < 12; i++) pop(2'b11);

        // R1: reset mid-run clears everything again
        push(8'hEE);
        do_reset();

        // Mixed pseudo-random traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[3], lfsr[1] & ~lfsr[5], lfsr[15:8],
                 (lfsr[7:4] == 4'hF), lfsr[6:5], lfsr[11:8]);
            if (i == 1000) do_reset();
        end

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule